// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block sits beside a 32-bit memory bus and decides how many wait cycles each access must take. The bus address space is split into 16 regions chosen by address bits [27:24]. A 16-bit wait-control register sets the timing of three cartridge ROM windows and of a save-RAM region. Each window covers a pair of adjacent regions. One bit of the register turns on prefetch, which removes the waits from prefetch fetches into the windows. The per-region wait values for 16-bit and 32-bit accesses, non-sequential and sequential, are all derived from that register. After reset the block behaves as if the register held zero.

A requester presents an address, a width flag, a sequential flag, a prefetch-fetch flag and a store flag, together with a one-cycle request. The block looks up the wait count and holds `stall` high for exactly that many cycles. It then pulses `done` and reports the total cost of the access on `acc_cycles`. A load costs two base cycles and a store costs one, plus the wait count in both cases.

Top module: `bus_wait_gen`

## Requirements
- R1: The region index is `req_addr[27:24]`; address bits outside that field do not change the wait. Regions 0, 1 and 3 to 7 always have zero wait.
- R2: After reset, 16-bit non-sequential waits are 4 for regions 8 to 14. 32-bit non-sequential waits are 7 for regions 8 and 9, 9 for regions 10 and 11, 13 for regions 12 and 13, and 9 for region 14. The 32-bit sequential wait of regions 12 and 13 is 17.
- R3: The window non-sequential codes sit in `cfg_wdata` bits [3:2] (window 0, regions 8 and 9), [6:5] (window 1, regions 10 and 11) and [9:8] (window 2, regions 12 and 13). A code selects a 16-bit wait: code 0 gives 4, code 1 gives 3, code 2 gives 2 and code 3 gives 8.
- R4: The sequential bits are bit 4 for window 0, bit 7 for window 1 and bit 10 for window 2. A set bit gives a 16-bit sequential wait of 1. A clear bit gives 2, 4 or 8 for windows 0, 1 and 2.
- R5: For a window, the 32-bit non-sequential wait is N16 + 1 + S16 and the 32-bit sequential wait is 2*S16 + 1.
- R6: The save-RAM code in bits [1:0] uses the same map as R3. For region 14 it gives one value V for both 16-bit wait kinds, and 2*V + 1 for both 32-bit kinds. Region 15 mirrors these values after the first register write and has zero wait before it.
- R7: With bit 14 clear, prefetch fetches to a window wait as long as sequential accesses. With bit 14 set, they wait 0. Prefetch fetches outside the windows use fixed values: region 2 waits 2 or 5, region 14 waits 4 or 9 (16-bit or 32-bit), and the other regions wait 0.
- R8: When `req_pf` is set, the prefetch wait is used even if `req_seq` is also set. Otherwise `req_seq` selects the sequential wait, and with both flags clear the non-sequential wait is used.
- R9: A request is taken when `req` is high and `stall` is low. For a wait W > 0, `stall` is high for exactly W cycles starting the cycle after acceptance, and `done` is high for the one cycle after the last stall cycle. For W = 0, `done` is high the cycle after acceptance and `stall` stays low.
- R10: While `done` is high, `acc_cycles` equals 2 + W for a load and 1 + W for a store (`req_store` high). It does not change while `stall` is high.
- R11: A request raised while `stall` is high is dropped and produces no `done`.
- R12: A register write takes effect for requests accepted at later clock edges. A request accepted at the same edge as a write uses the old setting, and an access already stalling keeps its count.
- R13: Region 2 waits 2 cycles for 16-bit accesses and 5 cycles for 32-bit accesses, in all modes and under any register setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the wait-control register |
| cfg_wdata | input | 16 | New wait-control register value |
| req | input | 1 | Access request, one cycle |
| req_addr | input | ADDR_W | Access address |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| req_seq | input | 1 | Sequential access |
| req_pf | input | 1 | Prefetch fetch |
| req_store | input | 1 | 1 = store, 0 = load |
| stall | output | 1 | Wait cycles in progress |
| done | output | 1 | Access complete pulse |
| acc_cycles | output | COST_W | Total access cost, valid with `done` |

## Verification
On every cycle the assertions check the stall and done handshake. They confirm that `done` follows each stall run and never overlaps it, and that a stall run begins only after a request. They also check that the reported cost matches the observed stall length plus the base cycles for a load or a store, and that zero-wait regions never stall. Only the scenarios in the bench can show the decoding itself: the field positions, the code maps, the sequential and 32-bit formulas for each window, the save-RAM mirror, and the prefetch collapse. The bench checks these by comparing each stall length with a value worked out by hand. The timing of register updates relative to accesses in flight is also shown only by the bench scenarios.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

   localparam int WAIT_BITS = 5;

   typedef logic [WAIT_BITS-1:0] wait_t;

   typedef struct packed {
      wait_t n16;
      wait_t s16;
      wait_t n32;
      wait_t s32;
      wait_t p16;
      wait_t p32;
   } wait_set_t;

   // two-bit non-sequential code to wait count
   function automatic wait_t nseq_map(input logic [1:0] code);
      case (code)
         2'd0:    return wait_t'(4);
         2'd1:    return wait_t'(3);
         2'd2:    return wait_t'(2);
         default: return wait_t'(8);
      endcase
   endfunction

   // sequential bit to wait count; the slow value doubles per window
   function automatic wait_t seq_map(input logic fast, input int win);
      return fast ? wait_t'(1) : wait_t'(2 << win);
   endfunction

   // derive the 32-bit waits from the 16-bit pair; prefetch follows sequential
   function automatic wait_set_t build_set(input wait_t n16, input wait_t s16);
      wait_set_t s;
      s.n16 = n16;
      s.s16 = s16;
      s.n32 = wait_t'(n16 + s16 + 1);
      s.s32 = wait_t'(2 * s16 + 1);
      s.p16 = s.s16;
      s.p32 = s.s32;
      return s;
   endfunction

endpackage

// File: rtl/bwg_table.sv
module bwg_table
   import bwg_pkg::*;
#(
   parameter int REGION_BITS = 4,
   parameter int N_WIN       = 3,
   parameter int WIN_BASE    = 8,
   parameter int SAVE_REGION = 14,
   parameter int WRAM_REGION = 2,
   parameter int FIELD_LSB   = 2,
   parameter int FIELD_STEP  = 3,
   parameter int PF_BIT      = 14,
   parameter bit MIRROR_EN   = 1'b1
) (
   input  logic [15:0]            cfg,
   input  logic                   mirror_live,
   input  logic [REGION_BITS-1:0] region,
   output wait_set_t              sel
);

   localparam int MIRROR_REGION = SAVE_REGION + 1;

   // save-RAM prefetch waits stay at their reset sequential values
   localparam wait_set_t SAVE_RESET = build_set(nseq_map(2'd0), nseq_map(2'd0));
   localparam wait_set_t WRAM_SET   = build_set(wait_t'(2), wait_t'(2));

   wait_set_t win_set [N_WIN];
   wait_set_t save_set;
   wait_set_t mirror_set;

   genvar w;
   generate
      for (w = 0; w < N_WIN; w++) begin : g_win
         localparam int NB = FIELD_LSB + FIELD_STEP * w;
         wait_set_t base;
         always_comb begin
            base = build_set(nseq_map(cfg[NB +: 2]), seq_map(cfg[NB + 2], w));
            if (cfg[PF_BIT]) begin
               base.p16 = '0;
               base.p32 = '0;
            end
         end
         assign win_set[w] = base;
      end
   endgenerate

   always_comb begin
      save_set     = build_set(nseq_map(cfg[1:0]), nseq_map(cfg[1:0]));
      save_set.p16 = SAVE_RESET.s16;
      save_set.p32 = SAVE_RESET.s32;
   end

   generate
      if (MIRROR_EN) begin : g_mirror
         always_comb begin
            mirror_set = '0;
            if (mirror_live) begin
               mirror_set     = save_set;
               mirror_set.p16 = '0;
               mirror_set.p32 = '0;
            end
         end
      end else begin : g_no_mirror
         logic unused_live;
         assign unused_live = mirror_live;
         assign mirror_set  = '0;
      end
   endgenerate

   always_comb begin
      sel = '0;
      if (region == REGION_BITS'(WRAM_REGION)) sel = WRAM_SET;
      if (region == REGION_BITS'(SAVE_REGION)) sel = save_set;
      if (region == REGION_BITS'(MIRROR_REGION)) sel = mirror_set;
      for (int k = 0; k < N_WIN; k++) begin
         if (region == REGION_BITS'(WIN_BASE + 2 * k) ||
             region == REGION_BITS'(WIN_BASE + 2 * k + 1))
            sel = win_set[k];
      end
   end

endmodule

// File: rtl/bwg_select.sv
module bwg_select
   import bwg_pkg::*;
(
   input  wait_set_t set,
   input  logic      wide,
   input  logic      seq,
   input  logic      pf,
   output wait_t     wait_val
);

   always_comb begin
      if (pf)
         wait_val = wide ? set.p32 : set.p16;
      else if (seq)
         wait_val = wide ? set.s32 : set.s16;
      else
         wait_val = wide ? set.n32 : set.n16;
   end

endmodule

// File: rtl/bwg_stall_ctr.sv
module bwg_stall_ctr #(
   parameter int WAIT_W = 5,
   parameter int COST_W = WAIT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WAIT_W-1:0] wait_val,
   input  logic              store,
   output logic              busy,
   output logic              done,
   output logic [COST_W-1:0] cost
);

   logic [WAIT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         cnt  <= '0;
         cost <= '0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            if (cnt == WAIT_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
            cnt <= cnt - WAIT_W'(1);
         end else if (start) begin
            cost <= COST_W'(wait_val) + (store ? COST_W'(1) : COST_W'(2));
            if (wait_val == '0) begin
               done <= 1'b1;
            end else begin
               busy <= 1'b1;
               cnt  <= wait_val;
            end
         end
      end
   end

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
   import bwg_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int REGION_LSB  = 24,
   parameter int REGION_BITS = 4,
   parameter int N_WIN       = 3,
   parameter int WIN_BASE    = 8,
   parameter int SAVE_REGION = 14,
   parameter int WRAM_REGION = 2,
   parameter bit MIRROR_EN   = 1'b1,
   localparam int COST_W     = WAIT_BITS + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [15:0]       cfg_wdata,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_wide,
   input  logic              req_seq,
   input  logic              req_pf,
   input  logic              req_store,
   output logic              stall,
   output logic              done,
   output logic [COST_W-1:0] acc_cycles
);

   localparam int FIELD_LSB  = 2;
   localparam int FIELD_STEP = 3;
   localparam int PF_BIT     = 14;

   generate
      if (REGION_LSB + REGION_BITS > ADDR_W) begin : g_bad_addr
         $error("region field exceeds address width");
      end
      if (REGION_BITS < 4) begin : g_bad_region
         $error("at least 16 regions are required");
      end
      if (FIELD_LSB + FIELD_STEP * N_WIN > PF_BIT || N_WIN < 1) begin : g_bad_win
         $error("window fields do not fit the control register");
      end
      if (WIN_BASE + 2 * N_WIN > SAVE_REGION) begin : g_bad_map
         $error("windows overlap the save-RAM region");
      end
   endgenerate

   logic [15:0]            cfg_q;
   logic                   mirror_live_q;
   logic [REGION_BITS-1:0] region;
   wait_set_t              set;
   wait_t                  wait_val;
   logic                   busy;
   logic                   unused_addr;

   assign region      = req_addr[REGION_LSB +: REGION_BITS];
   assign unused_addr = ^req_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q         <= '0;
         mirror_live_q <= 1'b0;
      end else if (cfg_we) begin
         cfg_q         <= cfg_wdata;
         mirror_live_q <= 1'b1;
      end
   end

   bwg_table #(
      .REGION_BITS (REGION_BITS),
      .N_WIN       (N_WIN),
      .WIN_BASE    (WIN_BASE),
      .SAVE_REGION (SAVE_REGION),
      .WRAM_REGION (WRAM_REGION),
      .FIELD_LSB   (FIELD_LSB),
      .FIELD_STEP  (FIELD_STEP),
      .PF_BIT      (PF_BIT),
      .MIRROR_EN   (MIRROR_EN)
   ) table_i (
      .cfg         (cfg_q),
      .mirror_live (mirror_live_q),
      .region      (region),
      .sel         (set)
   );

   bwg_select select_i (
      .set      (set),
      .wide     (req_wide),
      .seq      (req_seq),
      .pf       (req_pf),
      .wait_val (wait_val)
   );

   bwg_stall_ctr #(
      .WAIT_W (WAIT_BITS),
      .COST_W (COST_W)
   ) ctr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (req),
      .wait_val (wait_val),
      .store    (req_store),
      .busy     (busy),
      .done     (done),
      .cost     (acc_cycles)
   );

   assign stall = busy;

endmodule

// File: rtl/bus_wait_gen_chk.sv
module bus_wait_gen_chk #(
   parameter int ADDR_W     = 32,
   parameter int REGION_LSB = 24,
   parameter int COST_W     = 6,
   parameter int MAX_WAIT   = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_store,
   input logic              stall,
   input logic              done,
   input logic [COST_W-1:0] acc_cycles
);

   logic [COST_W-1:0] run;
   logic              st_l;
   logic              seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run  <= '0;
         st_l <= 1'b0;
         seen <= 1'b0;
      end else if (req && !stall) begin
         run  <= '0;
         st_l <= req_store;
         seen <= 1'b1;
      end else if (stall) begin
         run <= run + COST_W'(1);
      end
   end

   // R9
   stall_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(stall && done));

   // R9
   stall_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall) |-> done);

   // R9
   stall_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall) |-> $past(req));

   // R1
   zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !stall && req_addr[REGION_LSB +: 4] == 4'd3) |=> (done && !stall));

   // R10
   cost_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && seen) |-> acc_cycles == run + (st_l ? COST_W'(1) : COST_W'(2)));

   // R10
   cost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && $past(stall)) |-> $stable(acc_cycles));

   // R2
   max_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run <= COST_W'(MAX_WAIT));

endmodule

bind bus_wait_gen bus_wait_gen_chk #(
   .ADDR_W     (ADDR_W),
   .REGION_LSB (REGION_LSB),
   .COST_W     (COST_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req        (req),
   .req_addr   (req_addr),
   .req_store  (req_store),
   .stall      (stall),
   .done       (done),
   .acc_cycles (acc_cycles)
);

// File: tb/bus_wait_gen_tb_top.sv
`timescale 1ns/1ps
module bus_wait_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic        req = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_wide = 1'b0;
   logic        req_seq = 1'b0;
   logic        req_pf = 1'b0;
   logic        req_store = 1'b0;
   logic        stall;
   logic        done;
   logic [5:0]  acc_cycles;

   int n_chk = 0;
   int n_bad = 0;
   int n_push = 0;
   int n_pop = 0;
   int run = 0;
   bit finished = 1'b0;

   int    qw[$];
   int    qc[$];
   string qt[$];

   always #2 clk = ~clk;

   bus_wait_gen dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_wdata  (cfg_wdata),
      .req        (req),
      .req_addr   (req_addr),
      .req_wide   (req_wide),
      .req_seq    (req_seq),
      .req_pf     (req_pf),
      .req_store  (req_store),
      .stall      (stall),
      .done       (done),
      .acc_cycles (acc_cycles)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: measures stall runs and scores each completion
   always @(negedge clk) begin
      if (rst_n) begin
         if (stall) run++;
         if (done) begin
            if (qw.size() == 0) begin
               check(1'b0, "R11 unexpected done", 1, 0);
            end else begin
               int    w;
               int    c;
               string t;
               w = qw.pop_front();
               c = qc.pop_front();
               t = qt.pop_front();
               check(run == w, {t, " stall length"}, run, w);
               check(int'(acc_cycles) == c, {"R10 cost ", t}, int'(acc_cycles), c);
            end
            run = 0;
            n_pop++;
         end
      end
   end

   task automatic start_acc(input int region, input bit wide, input bit seq,
                            input bit pf, input bit store, input int w, input string tag);
      qw.push_back(w);
      qc.push_back(w + (store ? 1 : 2));
      qt.push_back(tag);
      n_push++;
      @(negedge clk);
      req       = 1'b1;
      req_addr  = (32'(region) << 24) | 32'h0000_0124;
      req_wide  = wide;
      req_seq   = seq;
      req_pf    = pf;
      req_store = store;
      @(negedge clk);
      req = 1'b0;
      if (w > 0)
         check(stall && !done, "R9 stall starts after accept", {stall, done}, 2);
      else
         check(done && !stall, "R9 zero-wait done", {stall, done}, 1);
   endtask

   task automatic finish_acc();
      while (n_pop != n_push) @(negedge clk);
   endtask

   task automatic acc(input int region, input bit wide, input bit seq,
                      input bit pf, input bit store, input int w, input string tag);
      start_acc(region, wide, seq, pf, store, w, tag);
      finish_acc();
   endtask

   task automatic cfg_write(input logic [15:0] v);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!stall && !done && acc_cycles == 0, "R9 reset state", {stall, done}, 0);

      // defaults (register value zero, prefetch off)
      acc(8, 0, 0, 0, 0, 4, "R2 r8 n16");
      acc(9, 1, 0, 0, 0, 7, "R2 r9 n32");
      acc(12, 1, 1, 0, 0, 17, "R2 r12 s32");
      acc(14, 1, 0, 0, 0, 9, "R2 r14 n32");
      acc(2, 1, 0, 0, 1, 5, "R13 r2 n32 store");
      acc(2, 0, 1, 0, 0, 2, "R13 r2 s16");
      acc(3, 1, 0, 0, 0, 0, "R1 r3");
      acc(16 + 7, 1, 1, 0, 0, 0, "R1 upper bits r7");
      acc(15, 0, 0, 0, 0, 0, "R6 mirror before write");
      acc(10, 0, 0, 1, 0, 4, "R7 pf equals seq at reset");

      // R12: a write at the accept edge does not affect that access
      qw.push_back(4); qc.push_back(6); qt.push_back("R12 same-edge write"); n_push++;
      @(negedge clk);
      req = 1'b1; req_addr = 32'h0800_0000; req_wide = 1'b0; req_seq = 1'b0;
      req_pf = 1'b0; req_store = 1'b0; cfg_we = 1'b1; cfg_wdata = 16'h063E;
      @(negedge clk);
      req = 1'b0; cfg_we = 1'b0;
      finish_acc();

      // register 0x063E: save code 2, w0 code3/fast, w1 code1/slow, w2 code2/fast
      acc(8, 0, 0, 0, 0, 8, "R3 w0 n16 code3");
      acc(9, 1, 0, 0, 0, 10, "R5 w0 n32");
      acc(9, 0, 1, 0, 0, 1, "R4 w0 s16 fast");
      acc(10, 0, 0, 0, 0, 3, "R3 w1 n16 code1");
      acc(10, 0, 1, 0, 0, 4, "R4 w1 s16 slow");
      acc(11, 1, 1, 0, 0, 9, "R5 w1 s32");
      acc(11, 1, 1, 0, 1, 9, "R10 store w1 s32");
      acc(13, 0, 0, 0, 0, 2, "R3 w2 n16 code2");
      acc(12, 0, 1, 0, 0, 1, "R4 w2 s16 fast");
      acc(12, 1, 1, 0, 0, 3, "R5 w2 s32");
      acc(14, 1, 0, 0, 0, 5, "R6 save n32");
      acc(14, 0, 1, 0, 0, 2, "R6 save s16");
      acc(15, 0, 0, 0, 0, 2, "R6 mirror live");
      acc(8, 0, 0, 1, 0, 1, "R7 pf off follows seq");

      // prefetch on
      cfg_write(16'h463E);
      acc(10, 1, 0, 1, 0, 0, "R7 pf on window");
      acc(14, 0, 0, 1, 0, 4, "R7 pf save fixed");
      acc(2, 1, 0, 1, 0, 5, "R7 pf r2 fixed");
      acc(11, 1, 1, 0, 0, 9, "R8 seq without pf");
      acc(11, 0, 1, 1, 0, 0, "R8 pf over seq");
      acc(9, 1, 0, 0, 0, 10, "R8 nonseq");

      // R12: an in-flight access keeps its count
      start_acc(12, 1, 0, 0, 0, 4, "R12 in-flight keeps count");
      cfg_write(16'h0000);
      finish_acc();
      acc(12, 1, 0, 0, 0, 13, "R12 new setting applies");

      // R11: request during stall is dropped
      start_acc(8, 0, 0, 0, 0, 4, "R11 base access");
      @(negedge clk);
      req = 1'b1; req_addr = 32'h0300_0000;
      @(negedge clk);
      req = 1'b0;
      finish_acc();
      repeat (3) @(negedge clk);
      check(n_pop == n_push && !done && !stall, "R11 no extra done", n_pop, n_push);

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         check(1'b0, "watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule